// File: doc/BRIEF.md
# Set-Associative Write-Back Cache Tag Controller

This block keeps the bookkeeping half of a data cache: for every set it stores the tags, a valid flag, a dirty flag and a recency order of its ways. It holds no data. Each clock it can take one request, made of a load/store flag and a 32-bit byte address. One cycle later it reports whether the block was present, and whether bringing it in pushed out a modified block that must be written back to memory.

Block size, way count and total capacity are power-of-two parameters. From them the block derives the number of sets and splits each address into a tag, a set index and a byte offset. A way count of 1 gives a direct-mapped cache. Stores follow write-back, write-allocate rules. A store that hits only marks the line modified. A store that misses installs the block the same way a load miss does, and the new line starts out modified. The memory transfer and any write buffer belong to the surrounding logic. This block only raises the writeback flag.

Top module: `cache_tag_ctrl`

## Requirements
- R1: After a synchronous reset `rsp_valid` is low, and every line is invalid and clean, so the first access to any block misses and reports no dirty eviction.
- R2: `rsp_valid` is high in exactly the cycle after a cycle in which `req_valid` was high. While `rsp_valid` is high exactly one of `rsp_hit` and `rsp_miss` is high. While it is low, `rsp_hit`, `rsp_miss` and `rsp_dirty_evict` are all low.
- R3: The address splits into offset bits [OFF-1:0] (OFF = log2 of the block size), then set index bits above them (log2 of capacity/(block × ways)), then the tag. Addresses that differ only in offset bits name the same block, and blocks in different sets never displace each other.
- R4: A load miss installs the block, so a following access to the same block hits.
- R5: A store hit marks the line modified and reports no dirty eviction.
- R6: A store miss installs the block like a load miss and marks it modified.
- R7: In a full set, a miss replaces the least recently used way, where both hits and fills count as use.
- R8: `rsp_dirty_evict` is high only on a miss whose replaced line was valid and modified. Replacing a clean line, or filling an empty way, leaves it low.
- R9: A miss fills an empty way before it replaces any valid one. A set touched by no more than the way count of distinct blocks therefore loses none of them.
- R10: A reset in mid-run discards all tags and modified flags. A block present before the reset misses afterwards, and its later replacement is clean.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | An access is presented this cycle |
| req_store | input | 1 | Access kind: 0 load, 1 store |
| req_addr | input | 32 | Byte address of the access |
| rsp_valid | output | 1 | Outcome of the previous cycle's access |
| rsp_hit | output | 1 | The access found its block |
| rsp_miss | output | 1 | The access did not find its block |
| rsp_dirty_evict | output | 1 | The miss replaced a modified line |

## Verification
Two things can happen in one response cycle: a miss that installs a new line and the writeback flag for the line it pushes out. Which way is the victim depends on the recency updates from earlier hits and fills. The bench sets this up by filling a set to its way count with a mix of stores and loads, refreshing some lines with hits, and then sending a new tag to that set. It also runs a long random stream confined to a few sets and a few tags. A behavioural recency-list model predicts hit, miss and writeback together on every cycle, and each response is judged against all three predictions at once.

// File: rtl/cache_tag_pkg.sv
package cache_tag_pkg;

   typedef enum logic {
      ACC_LOAD  = 1'b0,
      ACC_STORE = 1'b1
   } acc_kind_e;

   // Width of a field able to index n items, never less than one bit.
   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   // Number of address bits consumed by n items (zero when n is one).
   function automatic int unsigned field_bits(input int unsigned n);
      return (n > 1) ? $clog2(n) : 0;
   endfunction

endpackage

// File: rtl/cache_addr_split.sv
module cache_addr_split #(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned OFF_W    = 4,
   parameter int unsigned SET_BITS = 4,
   parameter int unsigned IDX_W    = 4,
   parameter int unsigned TAG_W    = 24
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [IDX_W-1:0]  set_idx,
   output logic [TAG_W-1:0]  tag
);

   generate
      if (SET_BITS == 0) begin : g_one_set
         assign set_idx = '0;
         assign tag     = addr[ADDR_W-1:OFF_W];
      end else begin : g_many_sets
         assign set_idx = addr[OFF_W +: SET_BITS];
         assign tag     = addr[ADDR_W-1:OFF_W+SET_BITS];
      end
   endgenerate

endmodule

// File: rtl/cache_way_match.sv
module cache_way_match #(
   parameter int unsigned WAYS  = 4,
   parameter int unsigned TAG_W = 24,
   parameter int unsigned WAY_W = 2
) (
   input  logic [WAYS-1:0]            row_valid,
   input  logic [WAYS-1:0][TAG_W-1:0] row_tag,
   input  logic [TAG_W-1:0]           look_tag,
   output logic                       hit,
   output logic [WAY_W-1:0]           hit_way,
   output logic                       has_free,
   output logic [WAY_W-1:0]           free_way
);

   always_comb begin
      hit      = 1'b0;
      hit_way  = '0;
      for (int w = 0; w < int'(WAYS); w++) begin
         if (row_valid[w] && (row_tag[w] == look_tag)) begin
            hit     = 1'b1;
            hit_way = WAY_W'(w);
         end
      end
   end

   // Lowest-numbered empty way wins: scan downwards so the last write is the lowest.
   always_comb begin
      has_free = 1'b0;
      free_way = '0;
      for (int w = int'(WAYS) - 1; w >= 0; w--) begin
         if (!row_valid[w]) begin
            has_free = 1'b1;
            free_way = WAY_W'(w);
         end
      end
   end

endmodule

// File: rtl/cache_lru_ages.sv
module cache_lru_ages #(
   parameter int unsigned WAYS  = 4,
   parameter int unsigned SETS  = 16,
   parameter int unsigned IDX_W = 4,
   parameter int unsigned WAY_W = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             touch,
   input  logic [IDX_W-1:0] touch_idx,
   input  logic [WAY_W-1:0] touch_way,
   input  logic [IDX_W-1:0] look_idx,
   output logic [WAY_W-1:0] oldest_way
);

   generate
      if (WAYS == 1) begin : g_direct
         logic unused_direct;
         assign unused_direct = ^{touch, touch_idx, touch_way, look_idx, clk, rst};
         assign oldest_way    = '0;
      end else begin : g_ages
         // Each way carries an age; 0 is most recent, WAYS-1 is the victim.
         logic [SETS-1:0][WAYS-1:0][WAY_W-1:0] age_q;
         logic [WAY_W-1:0]                     ref_age;

         assign ref_age = age_q[touch_idx][touch_way];

         always_ff @(posedge clk) begin
            if (rst) begin
               for (int s = 0; s < int'(SETS); s++)
                  for (int w = 0; w < int'(WAYS); w++)
                     age_q[s][w] <= WAY_W'(w);
            end else if (touch) begin
               for (int w = 0; w < int'(WAYS); w++) begin
                  if (WAY_W'(w) == touch_way)
                     age_q[touch_idx][w] <= '0;
                  else if (age_q[touch_idx][w] < ref_age)
                     age_q[touch_idx][w] <= age_q[touch_idx][w] + 1'b1;
               end
            end
         end

         always_comb begin
            oldest_way = '0;
            for (int w = 0; w < int'(WAYS); w++)
               if (age_q[look_idx][w] == WAY_W'(WAYS - 1))
                  oldest_way = WAY_W'(w);
         end
      end
   endgenerate

endmodule

// File: rtl/cache_tag_ctrl.sv
module cache_tag_ctrl
   import cache_tag_pkg::*;
#(
   parameter int unsigned ADDR_W         = 32,
   parameter int unsigned BLOCK_BYTES    = 16,
   parameter int unsigned WAYS           = 4,
   parameter int unsigned CAPACITY_BYTES = 1024
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   input  logic              req_store,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic              rsp_miss,
   output logic              rsp_dirty_evict
);

   localparam int unsigned SETS     = CAPACITY_BYTES / (BLOCK_BYTES * WAYS);
   localparam int unsigned OFF_W    = field_bits(BLOCK_BYTES);
   localparam int unsigned SET_BITS = field_bits(SETS);
   localparam int unsigned IDX_W    = idx_width(SETS);
   localparam int unsigned WAY_W    = idx_width(WAYS);
   localparam int unsigned TAG_W    = ADDR_W - OFF_W - SET_BITS;

   generate
      if ((BLOCK_BYTES & (BLOCK_BYTES - 1)) != 0 || BLOCK_BYTES < 2) begin : g_bad_block
         $error("BLOCK_BYTES must be a power of two of at least 2");
      end
      if ((WAYS & (WAYS - 1)) != 0 || WAYS < 1) begin : g_bad_ways
         $error("WAYS must be a power of two");
      end
      if ((CAPACITY_BYTES & (CAPACITY_BYTES - 1)) != 0) begin : g_bad_cap
         $error("CAPACITY_BYTES must be a power of two");
      end
      if (SETS < 1) begin : g_bad_sets
         $error("CAPACITY_BYTES must hold at least one full set");
      end
      if (TAG_W < 1) begin : g_bad_tag
         $error("ADDR_W leaves no tag bits");
      end
   endgenerate

   // ---------------- state ----------------
   logic [SETS-1:0][WAYS-1:0]            valid_q;
   logic [SETS-1:0][WAYS-1:0]            dirty_q;
   logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag_q;

   // ---------------- lookup ----------------
   logic [IDX_W-1:0] set_idx;
   logic [TAG_W-1:0] look_tag;
   logic             unused_offset;

   assign unused_offset = ^req_addr[OFF_W-1:0];

   cache_addr_split #(
      .ADDR_W  (ADDR_W),
      .OFF_W   (OFF_W),
      .SET_BITS(SET_BITS),
      .IDX_W   (IDX_W),
      .TAG_W   (TAG_W)
   ) i_split (
      .addr   (req_addr),
      .set_idx(set_idx),
      .tag    (look_tag)
   );

   logic             hit;
   logic [WAY_W-1:0] hit_way;
   logic             has_free;
   logic [WAY_W-1:0] free_way;
   logic [WAY_W-1:0] oldest_way;

   cache_way_match #(
      .WAYS (WAYS),
      .TAG_W(TAG_W),
      .WAY_W(WAY_W)
   ) i_match (
      .row_valid(valid_q[set_idx]),
      .row_tag  (tag_q[set_idx]),
      .look_tag (look_tag),
      .hit      (hit),
      .hit_way  (hit_way),
      .has_free (has_free),
      .free_way (free_way)
   );

   logic [WAY_W-1:0] use_way;
   logic             victim_dirty;
   logic             acc_store;

   assign acc_store    = (acc_kind_e'(req_store) == ACC_STORE);
   assign use_way      = hit ? hit_way : (has_free ? free_way : oldest_way);
   assign victim_dirty = !hit && !has_free && dirty_q[set_idx][oldest_way];

   cache_lru_ages #(
      .WAYS (WAYS),
      .SETS (SETS),
      .IDX_W(IDX_W),
      .WAY_W(WAY_W)
   ) i_lru (
      .clk       (clk),
      .rst       (rst),
      .touch     (req_valid),
      .touch_idx (set_idx),
      .touch_way (use_way),
      .look_idx  (set_idx),
      .oldest_way(oldest_way)
   );

   // ---------------- update ----------------
   always_ff @(posedge clk) begin
      if (rst) begin
         valid_q <= '0;
         dirty_q <= '0;
      end else if (req_valid) begin
         valid_q[set_idx][use_way] <= 1'b1;
         if (hit)
            dirty_q[set_idx][use_way] <= dirty_q[set_idx][use_way] | acc_store;
         else
            dirty_q[set_idx][use_way] <= acc_store;
      end
   end

   always_ff @(posedge clk) begin
      if (req_valid && !hit)
         tag_q[set_idx][use_way] <= look_tag;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rsp_valid       <= 1'b0;
         rsp_hit         <= 1'b0;
         rsp_miss        <= 1'b0;
         rsp_dirty_evict <= 1'b0;
      end else begin
         rsp_valid       <= req_valid;
         rsp_hit         <= req_valid && hit;
         rsp_miss        <= req_valid && !hit;
         rsp_dirty_evict <= req_valid && victim_dirty;
      end
   end

endmodule

// File: rtl/cache_tag_ctrl_chk.sv
module cache_tag_ctrl_chk #(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned BLOCK_BYTES = 16
) (
   input logic              clk,
   input logic              rst,
   input logic              req_valid,
   input logic [ADDR_W-1:0] req_addr,
   input logic              rsp_valid,
   input logic              rsp_hit,
   input logic              rsp_miss,
   input logic              rsp_dirty_evict
);

   localparam int unsigned OFF_W = (BLOCK_BYTES > 1) ? $clog2(BLOCK_BYTES) : 0;

   logic                    prev_v;
   logic [ADDR_W-OFF_W-1:0] prev_blk;

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_v   <= 1'b0;
         prev_blk <= '0;
      end else begin
         prev_v   <= req_valid;
         prev_blk <= req_addr[ADDR_W-1:OFF_W];
      end
   end

   a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !rsp_valid);

   a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
      req_valid |=> rsp_valid);

   a_r2_no_rsp_without_req: assert property (@(posedge clk) disable iff (rst)
      !req_valid |=> !rsp_valid);

   a_r2_single_outcome: assert property (@(posedge clk) disable iff (rst)
      rsp_valid |-> ($countones({rsp_hit, rsp_miss}) == 1));

   a_r2_idle_outputs_low: assert property (@(posedge clk) disable iff (rst)
      !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_dirty_evict));

   a_r8_dirty_only_on_miss: assert property (@(posedge clk) disable iff (rst)
      rsp_dirty_evict |-> rsp_miss);

   a_r4_back_to_back_hit: assert property (@(posedge clk) disable iff (rst)
      (req_valid && prev_v && (req_addr[ADDR_W-1:OFF_W] == prev_blk)) |=> rsp_hit);

endmodule

bind cache_tag_ctrl cache_tag_ctrl_chk #(
   .ADDR_W     (ADDR_W),
   .BLOCK_BYTES(BLOCK_BYTES)
) i_chk (
   .clk            (clk),
   .rst            (rst),
   .req_valid      (req_valid),
   .req_addr       (req_addr),
   .rsp_valid      (rsp_valid),
   .rsp_hit        (rsp_hit),
   .rsp_miss       (rsp_miss),
   .rsp_dirty_evict(rsp_dirty_evict)
);

// File: tb/test_cache_tag_ctrl.sv
module test_cache_tag_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int WAYS       = 4;
   // 16-byte blocks, 16 sets: offset [3:0], set index [7:4], tag [31:8]

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        req_valid = 1'b0;
   logic        req_store = 1'b0;
   logic [31:0] req_addr  = '0;
   logic        rsp_valid, rsp_hit, rsp_miss, rsp_dirty_evict;

   int tests_run = 0;
   int tests_failed = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   cache_tag_ctrl #(
      .ADDR_W        (32),
      .BLOCK_BYTES   (16),
      .WAYS          (WAYS),
      .CAPACITY_BYTES(1024)
   ) i_cache_tag_ctrl (
      .clk            (clk),
      .rst            (rst),
      .req_valid      (req_valid),
      .req_store      (req_store),
      .req_addr       (req_addr),
      .rsp_valid      (rsp_valid),
      .rsp_hit        (rsp_hit),
      .rsp_miss       (rsp_miss),
      .rsp_dirty_evict(rsp_dirty_evict)
   );

   // Reference: one recency list over all sets, most recent at the front.
   typedef struct {
      int unsigned set_no;
      int unsigned tag;
      bit          dirty;
   } line_t;

   line_t       model[$];
   logic [3:0]  exp_out = 4'b0000;   // {valid, hit, miss, dirty_evict}
   string       exp_req = "R1";

   function automatic logic [31:0] mk(input int unsigned tag, input int unsigned set_no,
                                      input int unsigned off);
      return (tag << 8) | ((set_no & 15) << 4) | (off & 15);
   endfunction

   task automatic predict(input bit v, input bit st, input logic [31:0] a);
      int unsigned s = a[7:4];
      int unsigned t = a[31:8];
      int          found = -1;
      int          count = 0;
      int          last = -1;
      line_t       e;
      bit          de = 1'b0;
      if (!v) begin
         exp_out = 4'b0000;
         return;
      end
      for (int i = 0; i < model.size(); i++) begin
         if (model[i].set_no == s) begin
            count++;
            last = i;
            if (model[i].tag == t) found = i;
         end
      end
      if (found >= 0) begin
         e = model[found];
         model.delete(found);
         e.dirty = e.dirty | st;
         model.push_front(e);
         exp_out = 4'b1100;
      end else begin
         if (count == WAYS) begin
            de = model[last].dirty;
            model.delete(last);
         end
         e.set_no = s;
         e.tag    = t;
         e.dirty  = st;
         model.push_front(e);
         exp_out = {3'b101, de};
      end
   endtask

   task automatic check_out();
      logic [3:0] act = {rsp_valid, rsp_hit, rsp_miss, rsp_dirty_evict};
      tests_run++;
      if (act !== exp_out) begin
         tests_failed++;
         $display("FAIL %s: {valid,hit,miss,dirty_evict} actual %b expected %b",
                  exp_req, act, exp_out);
      end
   endtask

   // Check the previous response, then present the next access.
   task automatic step(input bit v, input bit st, input logic [31:0] a, input string req);
      @(negedge clk);
      check_out();
      predict(v, st, a);
      exp_req   = req;
      req_valid = v;
      req_store = st;
      req_addr  = a;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      req_valid = 1'b0;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      model.delete();
      exp_out = 4'b0000;
      exp_req = "R1";
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      tests_failed++;
      $display("FAIL R2: watchdog actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
   end

   initial begin
      do_reset();
      // R1: quiet outputs after reset, first access misses cleanly
      step(0, 0, 32'h0, "R1");
      step(1, 0, mk(3, 1, 0), "R1");
      // R4 / R3: same block with different offset hits
      step(1, 0, mk(3, 1, 4), "R4");
      step(1, 0, mk(3, 1, 12), "R3");
      // R3: same tag in other sets is independent
      step(1, 0, mk(3, 2, 0), "R3");
      step(1, 0, mk(3, 3, 0), "R3");
      step(0, 0, 32'h0, "R2");
      step(1, 0, mk(3, 1, 8), "R3");
      // R9: four distinct blocks in set 6 all stay resident
      for (int k = 0; k < 4; k++) step(1, 0, mk(10 + k, 6, 0), "R9");
      for (int k = 0; k < 4; k++) step(1, 0, mk(10 + k, 6, 4), "R9");
      // R7: refresh tag 10, then a new tag replaces the oldest (tag 11)
      step(1, 0, mk(10, 6, 0), "R7");
      step(1, 0, mk(20, 6, 0), "R7");
      step(1, 0, mk(11, 6, 0), "R7");
      step(1, 0, mk(10, 6, 0), "R7");
      // R5 / R8: store hit, then push the modified line out
      step(1, 1, mk(10, 6, 0), "R5");
      for (int k = 0; k < 4; k++) step(1, 0, mk(30 + k, 6, 0), "R8");
      // R6: store misses fill set 9 modified; later loads evict them dirty
      for (int k = 0; k < 4; k++) step(1, 1, mk(40 + k, 9, 0), "R6");
      for (int k = 0; k < 4; k++) step(1, 0, mk(50 + k, 9, 0), "R6");
      // R8: clean victims report no writeback
      for (int k = 0; k < 4; k++) step(1, 0, mk(60 + k, 9, 0), "R8");
      step(0, 0, 32'h0, "R8");
      // R10: mid-run reset drops modified lines
      step(1, 1, mk(70, 12, 0), "R10");
      step(0, 0, 32'h0, "R10");
      do_reset();
      step(0, 0, 32'h0, "R1");
      step(1, 0, mk(70, 12, 0), "R10");
      for (int k = 0; k < 4; k++) step(1, 0, mk(71 + k, 12, 0), "R10");
      // Random stream over few sets and tags: R7 ordering and R8 writebacks
      for (int n = 0; n < 4000; n++) begin
         bit          v  = ($urandom_range(0, 9) < 8);
         bit          st = $urandom_range(0, 1);
         int unsigned t  = $urandom_range(0, 6);
         int unsigned s  = $urandom_range(0, 2);
         step(v, st, mk(t, s, $urandom_range(0, 15)), "R7");
      end
      step(0, 0, 32'h0, "R2");
      step(0, 0, 32'h0, "R2");
      $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
   end

endmodule